// File: doc/BRIEF.md
# Four-Lane Byte/Word Data FIFO

This block buffers the data for one direction of a serial flash controller. Storage is split into four byte-wide lanes, each holding sixteen entries. The host side can move a 32-bit word, which fills or drains one entry in every lane at once. It can also move a single byte, which works through lane 0 only. The serial engine side moves one byte per cycle. In word mode it walks the lanes 0, 1, 2, 3 in order, so the bytes leave in the same order they were packed into the word. In byte mode it stays on lane 0.

Two instances are used, one per direction. On the transmit instance the host pushes and the serial side pops. On the receive instance the serial side pushes and the host pops. The status flags are combinational views of the byte count, meant for a status register: full, half-full, empty, word-available and byte-available. An error pulse marks every request that was dropped. The mode input picks the capacity: 64 bytes in word mode and 16 bytes in byte mode. The mode may only change while the FIFO is empty.

Top module: `quad_lane_fifo`

## Requirements
- R1: After reset `empty`=1, and `full`, `half_full`, `word_avail`, `byte_avail` and `err` are all 0.
- R2: In word mode a host word push stores bits 8k+7:8k as byte k, for k=0..3. Serial pops return the bytes in push order, byte 0 of each word first, rotating through lanes 0 to 3.
- R3: In word mode serial pushes fill lanes 0 to 3 in order. A host word pop returns the oldest byte in bits 7:0 and the fourth-oldest in bits 31:24. `word_avail` is 1 exactly when word mode is selected and at least 4 bytes are held.
- R4: In word mode the capacity is 64 bytes. `full` rises after the 16th word push. A push that does not fit in the free space is dropped, and `err` is 1 in the following cycle.
- R5: In byte mode (`byte_mode`=1) host byte pushes, host byte pops and serial transfers all use lane 0, with a capacity of 16 bytes and first-in first-out order. `hw_rdata` bits 31:8 read 0.
- R6: `half_full` is 1 when the held byte count is at least half the current capacity: 32 in word mode, 8 in byte mode.
- R7: A pop that asks for more bytes than are held is dropped, and `err` is 1 in the following cycle. This covers a pop while empty and a word pop with fewer than 4 bytes held.
- R8: A host word access while `byte_mode`=1, or a host byte access while `byte_mode`=0, is dropped with `err` the following cycle.
- R9: Two push requests in one cycle, or two pop requests in one cycle, are all dropped with `err` the following cycle.
- R10: A push and a pop in the same cycle both take effect. The free-space test for the push uses the count held before that cycle's pop.
- R11: `empty` is 1 and `byte_avail` is 0 exactly when no byte is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_mode | input | 1 | 1: single-lane byte mode (16 bytes); 0: four-lane word mode (64 bytes) |
| hw_push_word | input | 1 | Host pushes a 32-bit word |
| hw_push_byte | input | 1 | Host pushes `hw_wdata[7:0]` |
| hw_wdata | input | 32 | Host write data |
| hw_pop_word | input | 1 | Host pops a word |
| hw_pop_byte | input | 1 | Host pops a byte |
| hw_rdata | output | 32 | Head data for host pops, valid in the cycle of the pop |
| sr_push | input | 1 | Serial side pushes one byte |
| sr_wdata | input | 8 | Serial push byte |
| sr_pop | input | 1 | Serial side pops one byte |
| sr_rdata | output | 8 | Head byte for the serial side |
| full | output | 1 | Byte count equals the capacity |
| half_full | output | 1 | Byte count at least half the capacity |
| empty | output | 1 | No byte held |
| word_avail | output | 1 | Word mode and at least 4 bytes held |
| byte_avail | output | 1 | At least one byte held |
| err | output | 1 | One-cycle pulse for a dropped request |

## Verification
Head data on `hw_rdata` and `sr_rdata` is combinational from the read pointer. The bench therefore samples it inside the same cycle as the pop, after the inputs have settled. The flags follow the byte count, so they reflect a request one clock after it. `err` is registered from the decision made in the request cycle, so it is also due one clock later. Each request is driven after a falling edge and cleared at the next falling edge. Flags and `err` are read at that second falling edge. A queue of expected bytes gives the order every pop is compared against.

// File: rtl/quad_lane_fifo.sv
module quad_lane_fifo #(
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  parameter int BW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                byte_mode,
  input  logic                hw_push_word,
  input  logic                hw_push_byte,
  input  logic [LANES*BW-1:0] hw_wdata,
  input  logic                hw_pop_word,
  input  logic                hw_pop_byte,
  output logic [LANES*BW-1:0] hw_rdata,
  input  logic                sr_push,
  input  logic [BW-1:0]       sr_wdata,
  input  logic                sr_pop,
  output logic [BW-1:0]       sr_rdata,
  output logic                full,
  output logic                half_full,
  output logic                empty,
  output logic                word_avail,
  output logic                byte_avail,
  output logic                err
);
  localparam int TOTAL = LANES * DEPTH;
  localparam int PW    = $clog2(TOTAL);
  localparam int LW    = $clog2(LANES);
  localparam int CW    = PW + 1;

  logic [PW-1:0] wp, rp, wbase, rbase;
  logic [CW-1:0] cnt, cap, push_sz, pop_sz;
  logic          any_push, any_pop, push_ok, pop_ok, push_err, pop_err;
  logic [BW-1:0] byte_in;
  logic [BW-1:0] lane_q [LANES];

  assign cap     = byte_mode ? CW'(DEPTH) : CW'(TOTAL);
  assign wbase   = byte_mode ? {wp[PW-1:LW], LW'(0)} : wp;
  assign rbase   = byte_mode ? {rp[PW-1:LW], LW'(0)} : rp;
  assign byte_in = hw_push_byte ? hw_wdata[BW-1:0] : sr_wdata;

  assign any_push = hw_push_word | hw_push_byte | sr_push;
  assign any_pop  = hw_pop_word | hw_pop_byte | sr_pop;
  assign push_sz  = hw_push_word ? CW'(LANES) : CW'(1);
  assign pop_sz   = hw_pop_word ? CW'(LANES) : CW'(1);

  assign push_ok = any_push
                 && ($countones({hw_push_word, hw_push_byte, sr_push}) == 1)
                 && !(hw_push_word && byte_mode) && !(hw_push_byte && !byte_mode)
                 && ((cap - cnt) >= push_sz);
  assign pop_ok  = any_pop
                 && ($countones({hw_pop_word, hw_pop_byte, sr_pop}) == 1)
                 && !(hw_pop_word && byte_mode) && !(hw_pop_byte && !byte_mode)
                 && (cnt >= pop_sz);
  assign push_err = any_push && !push_ok;
  assign pop_err  = any_pop && !pop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      err <= 1'b0;
    end else begin
      err <= push_err | pop_err;
      if (push_ok) wp <= wp + (byte_mode ? PW'(LANES) : PW'(push_sz));
      if (pop_ok)  rp <= rp + (byte_mode ? PW'(LANES) : PW'(pop_sz));
      cnt <= cnt + (push_ok ? push_sz : '0) - (pop_ok ? pop_sz : '0);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BW-1:0] lmem [DEPTH];
    logic [LW-1:0] wk, rk;
    logic [PW-1:0] wa, ra;
    assign wk = LW'(l) - wbase[LW-1:0];
    assign rk = LW'(l) - rbase[LW-1:0];
    assign wa = wbase + PW'(wk);
    assign ra = rbase + PW'(rk);
    assign lane_q[l] = lmem[ra[PW-1:LW]];
    always_ff @(posedge clk) begin
      if (push_ok) begin
        if (hw_push_word) lmem[wa[PW-1:LW]] <= hw_wdata[int'(wk)*BW +: BW];
        else if (wbase[LW-1:0] == LW'(l)) lmem[wa[PW-1:LW]] <= byte_in;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      if (byte_mode && k != 0) hw_rdata[k*BW +: BW] = '0;
      else hw_rdata[k*BW +: BW] = lane_q[LW'(rbase[LW-1:0] + LW'(k))];
    end
  end
  assign sr_rdata = lane_q[rbase[LW-1:0]];

  assign empty      = (cnt == '0);
  assign byte_avail = (cnt != '0);
  assign full       = (cnt == cap);
  assign half_full  = (cnt >= (cap >> 1));
  assign word_avail = !byte_mode && (cnt >= CW'(LANES));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(TOTAL));
  // R4
  full_push_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && any_push) |=> err);
  // R7
  empty_pop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && any_pop) |=> err);
  // R9
  dual_push_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_push_word && sr_push) |=> err);
  // R3
  word_mode_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_avail |-> !byte_mode);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_push && !any_pop) |=> ($stable(empty) && $stable(full) && !err));
endmodule

// File: tb/sim_quad_lane_fifo.sv
module sim_quad_lane_fifo;
  logic clk = 1'b0, rst_n = 1'b0, byte_mode = 1'b0;
  logic hw_push_word = 0, hw_push_byte = 0, hw_pop_word = 0, hw_pop_byte = 0;
  logic sr_push = 0, sr_pop = 0;
  logic [31:0] hw_wdata = '0, hw_rdata;
  logic [7:0]  sr_wdata = '0, sr_rdata;
  logic full, half_full, empty, word_avail, byte_avail, err;
  logic [31:0] got_w;
  logic [7:0]  got_s;
  logic [7:0]  exp_q [$];
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  quad_lane_fifo u0 (.clk, .rst_n, .byte_mode, .hw_push_word, .hw_push_byte,
    .hw_wdata, .hw_pop_word, .hw_pop_byte, .hw_rdata, .sr_push, .sr_wdata,
    .sr_pop, .sr_rdata, .full, .half_full, .empty, .word_avail, .byte_avail, .err);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic pw, pb, ow, ob, sp, so, input logic [31:0] wd, input logic [7:0] sd);
    hw_push_word = pw; hw_push_byte = pb; hw_pop_word = ow; hw_pop_byte = ob;
    sr_push = sp; sr_pop = so; hw_wdata = wd; sr_wdata = sd;
    #1;
    got_w = hw_rdata; got_s = sr_rdata;
    @(negedge clk);
    {hw_push_word, hw_push_byte, hw_pop_word, hw_pop_byte, sr_push, sr_pop} = '0;
  endtask

  task automatic push_word(input logic [31:0] d, input logic e, input string tag);
    cyc(1, 0, 0, 0, 0, 0, d, 0);
    check({tag, " err"}, err, e);
    if (!e) for (int k = 0; k < 4; k++) exp_q.push_back(d[k*8 +: 8]);
  endtask

  task automatic push_byte(input logic host, input logic [7:0] d, input logic e, input string tag);
    cyc(0, host, 0, 0, !host, 0, {24'h0, d}, d);
    check({tag, " err"}, err, e);
    if (!e) exp_q.push_back(d);
  endtask

  task automatic pop_ser(input logic e, input string tag);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    check({tag, " err"}, err, e);
    if (!e) check({tag, " data"}, got_s, exp_q.pop_front());
  endtask

  task automatic pop_word(input logic e, input string tag);
    logic [31:0] x;
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    check({tag, " err"}, err, e);
    if (!e) begin
      for (int k = 0; k < 4; k++) x[k*8 +: 8] = exp_q.pop_front();
      check({tag, " data"}, got_w, x);
    end
  endtask

  task automatic pop_byte(input logic e, input string tag);
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    check({tag, " err"}, err, e);
    if (!e) check({tag, " data"}, got_w, {24'h0, exp_q.pop_front()});
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 empty", empty, 1); check("R1 full", full, 0);
    check("R1 half", half_full, 0); check("R1 wavail", word_avail, 0);
    check("R11 bavail", byte_avail, 0); check("R1 err", err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      push_word(32'h03020100 + 32'h04040404 * i, 0, "R2 push");
      if (i == 6) check("R6 half below", half_full, 0);
      if (i == 7) check("R6 half at 32", half_full, 1);
    end
    check("R4 full", full, 1);
    push_word(32'hdeadbeef, 1, "R4 overflow");
    check("R4 still full", full, 1);
    cyc(1, 0, 0, 0, 0, 1, 32'hcafef00d, 0);
    check("R10 full push dropped err", err, 1);
    check("R10 pop data", got_s, exp_q.pop_front());
    check("R10 not full", full, 0);
    while (exp_q.size() > 0) pop_ser(0, "R2 drain");
    check("R11 empty", empty, 1); check("R11 bavail", byte_avail, 0);
    pop_ser(1, "R7 pop empty");

    for (int i = 0; i < 5; i++) push_byte(0, 8'h50 + 8'(i), 0, "R3 ser push");
    check("R3 wavail", word_avail, 1);
    pop_word(0, "R3 word pop");
    check("R3 wavail low", word_avail, 0); check("R11 bavail", byte_avail, 1);
    pop_word(1, "R7 short word pop");
    push_byte(1, 8'h77, 1, "R8 byte port word mode");
    cyc(1, 0, 0, 0, 1, 0, 32'h11223344, 8'h99);
    check("R9 dual push err", err, 1);
    pop_ser(0, "R9 after dual push");
    check("R9 empty", empty, 1);

    push_word(32'ha3a2a1a0, 0, "R10 first");
    cyc(1, 0, 0, 0, 0, 1, 32'hb3b2b1b0, 0);
    check("R10 both err", err, 0);
    check("R10 pop data", got_s, exp_q.pop_front());
    for (int k = 0; k < 4; k++) exp_q.push_back(8'hb0 + 8'(k));
    while (exp_q.size() > 0) pop_ser(0, "R10 drain");
    check("R10 empty", empty, 1);

    byte_mode = 1'b1;
    @(negedge clk);
    push_word(32'h01020304, 1, "R8 word port byte mode");
    check("R8 empty", empty, 1);
    for (int i = 0; i < 16; i++) begin
      push_byte(i % 2 == 0, 8'hc0 + 8'(i), 0, "R5 push");
      if (i == 6) check("R6 byte half below", half_full, 0);
      if (i == 7) check("R6 byte half at 8", half_full, 1);
    end
    check("R5 full", full, 1); check("R5 wavail", word_avail, 0);
    push_byte(1, 8'hee, 1, "R5 overflow");
    for (int i = 0; i < 16; i++) begin
      if (i % 3 == 0) pop_ser(0, "R5 ser pop"); else pop_byte(0, "R5 host pop");
    end
    check("R5 empty", empty, 1);
    pop_byte(1, "R7 byte pop empty");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule